// File: doc/BRIEF.md
# Sixteen-bit timer/counter with byte-wide register access

This peripheral holds a 16-bit up-counter that software reaches through a narrow byte-wide register port. Three byte registers (the count low byte, the count high byte and a control byte) plus a one-bit overflow flag register make up the visible state. Each count advance comes either from an internal tick or from edges on an external clock pin. The internal tick is the system clock divided by `SYS_DIV`. The pin can pass through a synchronizer chain or be sampled directly. Either tick source then feeds a power-of-two prescaler.

When the counter wraps past its all-ones value it raises a sticky flag. The flag, gated by an enable input, drives the interrupt line. A one-cycle pulse from a neighbouring compare unit zeroes the count. A two-bit field in the control byte tells the two capture/compare units whether to take their time base from this timer. Optionally, a shadow high byte lets software read or write all sixteen bits as one coherent value.

Top module: `ticktimer16`

## Requirements
- R1: After reset, all four registers read 0 (address 0 count low byte, 1 count high byte, 2 control, 3 flag in bit 0), `irq` is 0 and both time-base selects are 0.
- R2: With control bit 1 clear and bit 0 set, each internal tick (one per `SYS_DIV` clocks) is fed to the prescaler. Control bits 5:4 set the divide ratio: 00, 01, 10 and 11 give 1, 2, 4 and 8. After a count write, T ticks add floor(T/ratio) to the count.
- R3: An advance from 0xFFFF leaves 0x0000 and sets the flag. The flag remains set until a write of 0 to bit 0 of address 3. A wrap in the same cycle as that clearing write leaves the flag set.
- R4: `irq` is high exactly when the flag is set and `irq_en` is high.
- R5: A high `cmp_clr` makes the count 0 at the next clock edge. It overrides both a count write and an advance in the same cycle.
- R6: While control bit 0 is clear, the count holds its value, whatever arrives on the external pin or from the internal tick.
- R7: With control bit 1 set, rising edges of `ext_clk_in` feed the prescaler, but only once a falling edge has been seen since the timer was last enabled with the external source. The first rising edge after enabling from a low pin is therefore not counted.
- R8: Control bit 2 picks how the pin is sampled: 0 routes it through `SYNC_STAGES` flip-flops, 1 samples it directly. Both settings count the same edges. With the internal source selected, bit 2 has no effect.
- R9: With control bit 7 clear, addresses 0 and 1 read the live low and high byte, and a write to either one replaces only that byte.
- R10: With control bit 7 set, a read strobe on address 0 copies the live high byte into a shadow register. Reads of address 1 then return that shadow.
- R11: With control bit 7 set, a write to address 1 loads only the shadow. A later write to address 0 loads the count with {shadow, data}.
- R12: A write to address 0 or 1 restarts the prescaler. Rewriting the prescale field leaves the count unchanged.
- R13: `cmp0_this` equals control bit 6. `cmp1_this` is high when bit 6 or bit 3 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| bus_sel | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (side effect on address 0 only) |
| bus_wdata | input | BYTE_W | Write data |
| bus_rdata | output | BYTE_W | Read data for `bus_sel` |
| ext_clk_in | input | 1 | External count clock |
| cmp_clr | input | 1 | Count clear pulse from a compare unit |
| irq_en | input | 1 | Interrupt enable |
| irq | output | 1 | Overflow interrupt |
| cmp0_this | output | 1 | First capture/compare unit uses this timer |
| cmp1_this | output | 1 | Second capture/compare unit uses this timer |

## Verification
The bench builds the block with `SYS_DIV=1`, so every enabled clock is an internal tick. This lets the expected count for each prescale setting and run length be computed as a plain floor(T/ratio) over a sweep of all four ratios and several lengths. `SYNC_STAGES=2` and `BYTE_W=8` keep both pin-sampling paths in play. Both paths are then swept over pulse counts and ratios, with the expected value (pulses−1)/ratio, which covers the arming rule. Wrap, clear priority and the shadow byte paths are driven by short directed sequences whose results are worked out cycle by cycle.

// File: rtl/ticktimer_pkg.sv
package ticktimer_pkg;

   localparam int PS_W = 2;

   typedef enum logic [1:0] {
      REG_CNT_LO = 2'd0,
      REG_CNT_HI = 2'd1,
      REG_CTRL   = 2'd2,
      REG_FLAG   = 2'd3
   } reg_sel_e;

   // bit 7 down to bit 0
   typedef struct packed {
      logic            wide;
      logic            base_hi;
      logic [PS_W-1:0] pscale;
      logic            base_lo;
      logic            sync_off;
      logic            src_ext;
      logic            run;
   } ctrl_t;

   localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/ticktimer_tick_src.sv
module ticktimer_tick_src #(
   parameter int SYS_DIV     = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic src_ext,
   input  logic sync_off,
   input  logic ext_in,
   output logic tick
);

   logic int_tick;

   generate
      if (SYS_DIV == 1) begin : g_nodiv
         assign int_tick = 1'b1;
      end else begin : g_div
         localparam int DIV_W = $clog2(SYS_DIV);
         logic [DIV_W-1:0] div_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                            div_q <= '0;
            else if (div_q == DIV_W'(SYS_DIV - 1)) div_q <= '0;
            else                                   div_q <= div_q + DIV_W'(1);
         end
         assign int_tick = (div_q == DIV_W'(SYS_DIV - 1));
      end
   endgenerate

   logic [SYNC_STAGES-1:0] sync_q;

   generate
      if (SYNC_STAGES == 1) begin : g_sync1
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= '0;
            else        sync_q <= ext_in;
         end
      end else begin : g_syncn
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= '0;
            else        sync_q <= {sync_q[SYNC_STAGES-2:0], ext_in};
         end
      end
   endgenerate

   logic ext_lvl, prev_q, armed_q, rise, fall;

   assign ext_lvl = sync_off ? ext_in : sync_q[SYNC_STAGES-1];
   assign rise    = ext_lvl & ~prev_q;
   assign fall    = ~ext_lvl & prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q  <= 1'b0;
         armed_q <= 1'b0;
      end else begin
         prev_q <= ext_lvl;
         if (!(run && src_ext)) armed_q <= 1'b0;
         else if (fall)         armed_q <= 1'b1;
      end
   end

   assign tick = run & (src_ext ? (rise & armed_q) : int_tick);

endmodule

// File: rtl/ticktimer_prescale.sv
module ticktimer_prescale #(
   parameter int PS_W = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr,
   input  logic            tick,
   input  logic [PS_W-1:0] ps,
   output logic            adv
);

   localparam int PRE_W = (1 << PS_W) - 1;

   logic [PRE_W-1:0] pre_q;
   logic [PRE_W-1:0] mask;

   always_comb mask = PRE_W'((1 << ps) - 1);

   assign adv = tick & ((pre_q & mask) == mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    pre_q <= '0;
      else if (clr)  pre_q <= '0;
      else if (tick) pre_q <= pre_q + PRE_W'(1);
   end

endmodule

// File: rtl/ticktimer_regs.sv
module ticktimer_regs
   import ticktimer_pkg::*;
#(
   parameter int BYTE_W = 8,
   localparam int CNT_W = 2 * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        bus_sel,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [BYTE_W-1:0] bus_wdata,
   output logic [BYTE_W-1:0] bus_rdata,
   input  logic              cmp_clr,
   input  logic              adv,
   output ctrl_t             ctrl,
   output logic [CNT_W-1:0]  cnt,
   output logic              flag,
   output logic              cnt_load,
   output logic              cnt_wr
);

   ctrl_t              ctrl_q;
   logic [CNT_W-1:0]   cnt_q;
   logic [BYTE_W-1:0]  shadow_q;
   logic               flag_q;
   logic wr_lo, wr_hi, wr_ctrl, wr_flag, rd_lo, hi_direct, inc_go, wrap;

   assign wr_lo     = bus_wr && (bus_sel == REG_CNT_LO);
   assign wr_hi     = bus_wr && (bus_sel == REG_CNT_HI);
   assign wr_ctrl   = bus_wr && (bus_sel == REG_CTRL);
   assign wr_flag   = bus_wr && (bus_sel == REG_FLAG);
   assign rd_lo     = bus_rd && (bus_sel == REG_CNT_LO);
   assign hi_direct = wr_hi & ~ctrl_q.wide;
   assign cnt_load  = cmp_clr | wr_lo | hi_direct;
   assign cnt_wr    = wr_lo | wr_hi;
   assign inc_go    = adv & ~cnt_load;
   assign wrap      = inc_go & (&cnt_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl_q <= '0;
      else if (wr_ctrl) ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cnt_q <= '0;
      else if (cmp_clr)   cnt_q <= '0;
      else if (wr_lo)     cnt_q <= ctrl_q.wide ? {shadow_q, bus_wdata}
                                               : {cnt_q[CNT_W-1:BYTE_W], bus_wdata};
      else if (hi_direct) cnt_q <= {bus_wdata, cnt_q[BYTE_W-1:0]};
      else if (inc_go)    cnt_q <= cnt_q + CNT_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      shadow_q <= '0;
      else if (wr_hi && ctrl_q.wide)   shadow_q <= bus_wdata;
      else if (rd_lo && ctrl_q.wide)   shadow_q <= cnt_q[CNT_W-1:BYTE_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       flag_q <= 1'b0;
      else if (wrap)    flag_q <= 1'b1;
      else if (wr_flag) flag_q <= bus_wdata[0];
   end

   always_comb begin
      case (bus_sel)
         REG_CNT_LO: bus_rdata = cnt_q[BYTE_W-1:0];
         REG_CNT_HI: bus_rdata = ctrl_q.wide ? shadow_q : cnt_q[CNT_W-1:BYTE_W];
         REG_CTRL:   bus_rdata = BYTE_W'(ctrl_q);
         default:    bus_rdata = BYTE_W'(flag_q);
      endcase
   end

   assign ctrl = ctrl_q;
   assign cnt  = cnt_q;
   assign flag = flag_q;

endmodule

// File: rtl/ticktimer16.sv
module ticktimer16
   import ticktimer_pkg::*;
#(
   parameter int BYTE_W      = 8,
   parameter int SYS_DIV     = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        bus_sel,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [BYTE_W-1:0] bus_wdata,
   output logic [BYTE_W-1:0] bus_rdata,
   input  logic              ext_clk_in,
   input  logic              cmp_clr,
   input  logic              irq_en,
   output logic              irq,
   output logic              cmp0_this,
   output logic              cmp1_this
);

   localparam int CNT_W = 2 * BYTE_W;

   generate
      if (BYTE_W < CTRL_W) begin : g_bad_byte
         $error("ticktimer16: BYTE_W must hold the control byte");
      end
      if (SYS_DIV < 1) begin : g_bad_div
         $error("ticktimer16: SYS_DIV must be at least 1");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("ticktimer16: SYNC_STAGES must be at least 1");
      end
   endgenerate

   ctrl_t            ctrl;
   logic [CNT_W-1:0] count_q;
   logic             flag_q, run_on, tick, adv, cnt_load, cnt_wr;

   assign run_on = ctrl.run;

   ticktimer_tick_src #(
      .SYS_DIV     (SYS_DIV),
      .SYNC_STAGES (SYNC_STAGES)
   ) src_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run_on),
      .src_ext  (ctrl.src_ext),
      .sync_off (ctrl.sync_off),
      .ext_in   (ext_clk_in),
      .tick     (tick)
   );

   ticktimer_prescale #(
      .PS_W (PS_W)
   ) pre_i (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (cnt_wr | cmp_clr),
      .tick  (tick),
      .ps    (ctrl.pscale),
      .adv   (adv)
   );

   ticktimer_regs #(
      .BYTE_W (BYTE_W)
   ) regs_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .cmp_clr   (cmp_clr),
      .adv       (adv),
      .ctrl      (ctrl),
      .cnt       (count_q),
      .flag      (flag_q),
      .cnt_load  (cnt_load),
      .cnt_wr    (cnt_wr)
   );

   assign irq       = flag_q & irq_en;
   assign cmp0_this = ctrl.base_hi;
   assign cmp1_this = ctrl.base_hi | ctrl.base_lo;

endmodule

// File: rtl/ticktimer16_chk.sv
module ticktimer16_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cmp_clr,
   input logic             irq,
   input logic             irq_en,
   input logic             cmp0_this,
   input logic             cmp1_this,
   input logic             run,
   input logic             adv,
   input logic             cnt_load,
   input logic             flag,
   input logic [CNT_W-1:0] count
);

   a_r4_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> irq_en);

   a_r4_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> flag);

   a_r5_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_clr |=> (count == '0));

   a_r6_no_advance_off: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> !adv);

   a_r6_count_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !cnt_load) |=> (count == $past(count)));

   a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !cnt_load) |=> (count == $past(count) + CNT_W'(1)));

   a_r3_wrap_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !cnt_load && (&count)) |=> (flag && count == '0));

   a_r13_select_order: assert property (@(posedge clk) disable iff (!rst_n)
      cmp0_this |-> cmp1_this);

endmodule

bind ticktimer16 ticktimer16_chk #(
   .CNT_W (CNT_W)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmp_clr   (cmp_clr),
   .irq       (irq),
   .irq_en    (irq_en),
   .cmp0_this (cmp0_this),
   .cmp1_this (cmp1_this),
   .run       (run_on),
   .adv       (adv),
   .cnt_load  (cnt_load),
   .flag      (flag_q),
   .count     (count_q)
);

// File: tb/ticktimer16_tb_top.sv
`timescale 1ns/1ps
module ticktimer16_tb_top;

   localparam logic [1:0] A_LO = 2'd0, A_HI = 2'd1, A_CTRL = 2'd2, A_FLAG = 2'd3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] bus_sel = 2'd0;
   logic       bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0] bus_wdata = 8'd0;
   logic [7:0] bus_rdata;
   logic       ext_clk_in = 1'b0, cmp_clr = 1'b0, irq_en = 1'b0;
   logic       irq, cmp0_this, cmp1_this;

   int  n_chk = 0;
   int  n_bad = 0;
   bit  done = 1'b0;

   always #10 clk = ~clk;

   ticktimer16 #(.BYTE_W(8), .SYS_DIV(1), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_clk_in(ext_clk_in),
      .cmp_clr(cmp_clr), .irq_en(irq_en), .irq(irq),
      .cmp0_this(cmp0_this), .cmp1_this(cmp1_this)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // called at a negedge, returns at the next negedge
   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      bus_sel = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd_strobe(input logic [1:0] a, output logic [7:0] d);
      bus_sel = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic peek(input logic [1:0] a, output logic [7:0] d);
      bus_sel = a;
      #1 d = bus_rdata;
   endtask

   task automatic get_cnt(output logic [15:0] c);
      logic [7:0] lo, hi;
      peek(A_LO, lo);
      peek(A_HI, hi);
      c = {hi, lo};
   endtask

   task automatic set_cnt(input logic [15:0] c);
      wr(A_LO, c[7:0]);
      wr(A_HI, c[15:8]);
   endtask

   task automatic ext_pulse();
      ext_clk_in = 1'b1;
      repeat (3) @(negedge clk);
      ext_clk_in = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [7:0]  d;
      logic [15:0] c;
      int          lens[7] = '{1, 2, 3, 5, 8, 13, 17};
      int          pulses[4] = '{1, 2, 5, 9};
      int          ratios[3] = '{0, 1, 3};

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      for (int a = 0; a < 4; a++) begin
         peek(2'(a), d);
         check($sformatf("R1 reg %0d after reset", a), d, 0);
      end
      check("R1 irq after reset", irq, 0);
      check("R1 selects after reset", {cmp0_this, cmp1_this}, 0);

      // R13 time-base selects over all field codes
      for (int v = 0; v < 4; v++) begin
         wr(A_CTRL, 8'((v[1] << 6) | (v[0] << 3)));
         #1;
         check($sformatf("R13 cmp0 code %0d", v), cmp0_this, v[1]);
         check($sformatf("R13 cmp1 code %0d", v), cmp1_this, (v != 0));
      end
      wr(A_CTRL, 8'h00);

      // R2 / R8 internal source sweep: every clock is a tick
      for (int ps = 0; ps < 4; ps++) begin
         for (int ti = 0; ti < 7; ti++) begin
            logic [7:0] cv;
            cv = 8'((ps << 4) | ((ti % 2) << 2) | 1);
            set_cnt(16'h0000);
            wr(A_CTRL, cv);
            repeat (lens[ti] - 1) @(negedge clk);
            wr(A_CTRL, cv & 8'hFE);
            get_cnt(c);
            check($sformatf("R2 R8 internal ps=%0d T=%0d", ps, lens[ti]), c, lens[ti] >> ps);
         end
      end

      // R7 / R8 external source sweep
      for (int so = 0; so < 2; so++) begin
         for (int pi = 0; pi < 3; pi++) begin
            for (int qi = 0; qi < 4; qi++) begin
               set_cnt(16'h0000);
               ext_clk_in = 1'b0;
               wr(A_CTRL, 8'((ratios[pi] << 4) | (so << 2) | 3));
               for (int p = 0; p < pulses[qi]; p++) ext_pulse();
               repeat (4) @(negedge clk);
               wr(A_CTRL, 8'h00);
               get_cnt(c);
               check($sformatf("R7 R8 external sync_off=%0d ps=%0d pulses=%0d",
                               so, ratios[pi], pulses[qi]), c, (pulses[qi] - 1) >> ratios[pi]);
            end
         end
      end

      // R6 disabled: pin edges and idle clocks ignored
      set_cnt(16'h0042);
      wr(A_CTRL, 8'h02);
      for (int p = 0; p < 3; p++) ext_pulse();
      wr(A_CTRL, 8'h00);
      repeat (10) @(negedge clk);
      get_cnt(c);
      check("R6 frozen while disabled", c, 16'h0042);

      // R9 byte mode writes touch one byte
      wr(A_LO, 8'h34);
      peek(A_HI, d);
      check("R9 low write keeps high", d, 8'h00);
      wr(A_HI, 8'h12);
      get_cnt(c);
      check("R9 byte writes", c, 16'h1234);

      // R11 wide mode write through shadow
      wr(A_CTRL, 8'h80);
      wr(A_HI, 8'hAB);
      peek(A_LO, d);
      check("R11 high write leaves low", d, 8'h34);
      wr(A_CTRL, 8'h00);
      peek(A_HI, d);
      check("R11 high write not yet live", d, 8'h12);
      wr(A_CTRL, 8'h80);
      wr(A_LO, 8'hCD);
      wr(A_CTRL, 8'h00);
      get_cnt(c);
      check("R11 low write commits", c, 16'hABCD);

      // R10 wide mode coherent read
      set_cnt(16'h12FD);
      wr(A_CTRL, 8'h81);
      rd_strobe(A_LO, d);
      check("R10 low byte read", d, 8'hFD);
      repeat (3) @(negedge clk);
      wr(A_CTRL, 8'h80);
      peek(A_HI, d);
      check("R10 high from shadow", d, 8'h12);
      peek(A_LO, d);
      check("R10 live low", d, 8'h02);
      wr(A_CTRL, 8'h00);
      peek(A_HI, d);
      check("R10 live high", d, 8'h13);

      // R12 count write restarts prescaler; field change keeps count
      set_cnt(16'h0000);
      wr(A_CTRL, 8'h21);
      repeat (2) @(negedge clk);
      wr(A_CTRL, 8'h20);
      wr(A_LO, 8'h00);
      wr(A_CTRL, 8'h21);
      repeat (2) @(negedge clk);
      wr(A_CTRL, 8'h20);
      get_cnt(c);
      check("R12 prescaler restarted by write", c, 16'h0000);
      set_cnt(16'h0005);
      wr(A_CTRL, 8'h30);
      get_cnt(c);
      check("R12 prescale change keeps count", c, 16'h0005);

      // R3 / R4 wrap and flag
      irq_en = 1'b0;
      set_cnt(16'hFFFE);
      wr(A_CTRL, 8'h01);
      repeat (2) @(negedge clk);
      wr(A_CTRL, 8'h00);
      get_cnt(c);
      check("R3 count after wrap", c, 16'h0001);
      repeat (5) @(negedge clk);
      peek(A_FLAG, d);
      check("R3 flag sticky", d, 8'h01);
      check("R4 irq masked", irq, 0);
      irq_en = 1'b1;
      #1 check("R4 irq enabled", irq, 1);
      wr(A_FLAG, 8'h00);
      peek(A_FLAG, d);
      check("R3 flag cleared by write", d, 8'h00);
      check("R4 irq after clear", irq, 0);
      set_cnt(16'hFFFF);
      wr(A_CTRL, 8'h01);
      wr(A_FLAG, 8'h00);
      wr(A_CTRL, 8'h00);
      peek(A_FLAG, d);
      check("R3 set beats clear", d, 8'h01);
      get_cnt(c);
      check("R3 count after same-cycle wrap", c, 16'h0001);
      wr(A_FLAG, 8'h00);
      irq_en = 1'b0;

      // R5 compare clear
      set_cnt(16'h0100);
      wr(A_CTRL, 8'h01);
      repeat (4) @(negedge clk);
      cmp_clr = 1'b1;
      @(negedge clk);
      cmp_clr = 1'b0;
      get_cnt(c);
      check("R5 clear while counting", c, 16'h0000);
      @(negedge clk);
      get_cnt(c);
      check("R5 counting resumes", c, 16'h0001);
      wr(A_CTRL, 8'h00);
      set_cnt(16'h0100);
      cmp_clr = 1'b1;
      wr(A_LO, 8'h55);
      cmp_clr = 1'b0;
      get_cnt(c);
      check("R5 clear beats write", c, 16'h0000);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule